// File: doc/BRIEF.md
# Prescaled Wide Up-Counter

This block is a free-running binary up-counter, 64 bits wide by default. It must produce a correct full-width count on every clock at high clock rates. The count is split into two fields. A narrow prescaler field of two or three bits sits at the least significant end and steps on every enabled cycle. A wide upper field steps only when the prescaler is about to roll over.

The rollover condition is decoded one cycle early and held in a register. The upper field therefore sees a clean, registered enable. Its value changes at most once every 2^FAST_W cycles, so the path from the upper register through its incrementer and back may be constrained as a multicycle path.

A synchronous clear and a count enable control the whole counter. The output is the concatenation {upper, prescaler}. On every cycle it matches what a plain single-register counter would hold.

Top module: `prescaled_counter`

## Requirements
- R1: While reset is active and on the first cycle after its release, `count` is zero.
- R2: With `en` high and `clr` low, `count` increases by exactly one at each rising clock edge.
- R3: The upper field (`count[TOTAL_W-1:FAST_W]`) steps by one only at the edge where the prescaler field (`count[FAST_W-1:0]`) goes from all ones to zero. At every other enabled edge it keeps its value.
- R4: With `en` low and `clr` low, `count` keeps its value at the next edge. This holds even when the prescaler field is all ones, so that no carry leaks into the upper field.
- R5: With `clr` high, `count` is zero after the next edge, whatever `en` is.
- R6: `clr` takes priority over `en`. A clear applied while the prescaler field is all ones leaves no pending carry, so the first enabled edge after it gives a count of one.
- R7: Counting past the all-ones value wraps the whole count to zero.
- R8: With `FAST_W` set to 3, the counter obeys R2 to R7 unchanged.
- R9: Between two steps of the upper field that are not caused by a clear, at least 2^FAST_W clock cycles pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the whole count |
| en | input | 1 | Count enable |
| count | output | TOTAL_W | Full count {upper field, prescaler field} |

## Verification
Every result is due exactly one rising edge after the inputs that cause it. This holds for a step, a hold and a clear, including a carry into the upper field, because the output is taken straight from the field registers and the terminal flag is already registered.

The driver applies inputs on the falling edge and queues the reference value for that edge. The monitor pops one item per rising edge, just after the edge, and compares it with `count`.

A second instance with a narrow total width and a three-bit prescaler shares the same stimulus. It reaches the wrap point within the run. The monitor also measures the gap between upper-field steps on the wide instance.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  // Per-cycle operation, decoded once at the top with clear first.
  typedef enum logic [1:0] {
    PWC_HOLD  = 2'd0,
    PWC_STEP  = 2'd1,
    PWC_CLEAR = 2'd2
  } pwc_op_e;

endpackage

// File: rtl/pwc_fast_stage.sv
module pwc_fast_stage
  import pwc_pkg::*;
#(
  parameter int FAST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pwc_op_e           op,
  output logic [FAST_W-1:0] fast_q,
  output logic              tc_q
);

  localparam logic [FAST_W-1:0] ALL_ONES = '1;
  localparam logic [FAST_W-1:0] PENULT   = ALL_ONES ^ {{(FAST_W-1){1'b0}}, 1'b1};

  logic [FAST_W-1:0] fast_d;
  logic              tc_d;
  logic              fast_ce;

  // Next state. The terminal flag is decoded from the value before the
  // rollover, so it is a register output on the cycle the field is all ones.
  always_comb begin
    fast_d  = fast_q;
    tc_d    = tc_q;
    fast_ce = 1'b0;
    unique case (op)
      PWC_CLEAR: begin
        fast_d  = '0;
        tc_d    = 1'b0;
        fast_ce = 1'b1;
      end
      PWC_STEP: begin
        fast_d  = fast_q + {{(FAST_W-1){1'b0}}, 1'b1};
        tc_d    = (fast_q == PENULT);
        fast_ce = 1'b1;
      end
      default: begin
        fast_d  = fast_q;
        tc_d    = tc_q;
        fast_ce = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= '0;
      tc_q   <= 1'b0;
    end else if (fast_ce) begin
      fast_q <= fast_d;
      tc_q   <= tc_d;
    end
  end

endmodule

// File: rtl/pwc_slow_stage.sv
module pwc_slow_stage
  import pwc_pkg::*;
#(
  parameter int SLOW_W = 62
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pwc_op_e           op,
  input  logic              carry_in,
  output logic [SLOW_W-1:0] slow_q
);

  logic [SLOW_W-1:0] slow_inc;
  logic [SLOW_W-1:0] slow_d;
  logic              slow_ce;

  // Relaxed path: slow_q -> slow_inc -> slow_q. The register loads only on
  // a carry (at most once per prescaler period) or a clear (constant zero).
  assign slow_inc = slow_q + {{(SLOW_W-1){1'b0}}, 1'b1};

  always_comb begin
    slow_ce = 1'b0;
    slow_d  = slow_inc;
    unique case (op)
      PWC_CLEAR: begin
        slow_ce = 1'b1;
        slow_d  = '0;
      end
      PWC_STEP: begin
        slow_ce = carry_in;
        slow_d  = slow_inc;
      end
      default: begin
        slow_ce = 1'b0;
        slow_d  = slow_inc;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= '0;
    end else if (slow_ce) begin
      slow_q <= slow_d;
    end
  end

endmodule

// File: rtl/prescaled_counter.sv
module prescaled_counter
  import pwc_pkg::*;
#(
  parameter int TOTAL_W = 64,
  parameter int FAST_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               en,
  output logic [TOTAL_W-1:0] count
);

  localparam int SLOW_W = TOTAL_W - FAST_W;

  pwc_op_e           op;
  logic [FAST_W-1:0] fast_q;
  logic [SLOW_W-1:0] slow_q;
  logic              tc_q;

  // Clear wins over enable.
  always_comb begin
    if (clr)     op = PWC_CLEAR;
    else if (en) op = PWC_STEP;
    else         op = PWC_HOLD;
  end

  pwc_fast_stage #(
    .FAST_W (FAST_W)
  ) u_fast (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .fast_q (fast_q),
    .tc_q   (tc_q)
  );

  pwc_slow_stage #(
    .SLOW_W (SLOW_W)
  ) u_slow (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .carry_in (tc_q),
    .slow_q   (slow_q)
  );

  assign count = {slow_q, fast_q};

endmodule

// File: rtl/prescaled_counter_chk.sv
module prescaled_counter_chk #(
  parameter int TOTAL_W = 64,
  parameter int FAST_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr,
  input logic               en,
  input logic [TOTAL_W-1:0] count,
  input logic               tc_q
);

  localparam logic [TOTAL_W-1:0] ONE_W = {{(TOTAL_W-1){1'b0}}, 1'b1};
  localparam int GAP_W = FAST_W + 2;
  localparam logic [GAP_W-1:0] MIN_GAP = GAP_W'((1 << FAST_W) - 1);
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic [GAP_W-1:0] gap_q;
  logic             upper_load;

  assign upper_load = en && !clr && tc_q;

  // Cycles since the upper field last loaded, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (clr || upper_load) begin
      gap_q <= '0;
    end else if (gap_q != GAP_MAX) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (count == $past(count) + ONE_W)); // R2

  AST_UPPER_ONLY_ON_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(&count[FAST_W-1:0])) |=> (count[TOTAL_W-1:FAST_W] == $past(count[TOTAL_W-1:FAST_W]))); // R3

  AST_TC_TRACKS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q == (&count[FAST_W-1:0])); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(count)); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0)); // R5

  AST_CARRY_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    upper_load |-> (gap_q >= MIN_GAP)); // R9

endmodule

bind prescaled_counter prescaled_counter_chk #(
  .TOTAL_W (TOTAL_W),
  .FAST_W  (FAST_W)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .clr   (clr),
  .en    (en),
  .count (count),
  .tc_q  (tc_q)
);

// File: tb/prescaled_counter_tb_top.sv
`timescale 1ns/1ps
module prescaled_counter_tb_top;

  localparam int WA = 64;
  localparam int FA = 2;
  localparam int WB = 10;
  localparam int FB = 3;

  typedef struct {
    logic [WA-1:0] exp_a;
    logic [WB-1:0] exp_b;
    string         tag_a;
    string         tag_b;
    bit            clr_item;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          clr;
  logic          en;
  logic [WA-1:0] count_a;
  logic [WB-1:0] count_b;

  int checks;
  int errors;

  exp_t          sb_q[$];
  logic [WA-1:0] ref_a;
  logic [WB-1:0] ref_b;

  logic [WA-FA-1:0] last_upper;
  int               upper_gap;
  bit               mon_on;

  prescaled_counter #(.TOTAL_W(WA), .FAST_W(FA)) dut_i (
    .clk (clk), .rst_n (rst_n), .clr (clr), .en (en), .count (count_a)
  );

  prescaled_counter #(.TOTAL_W(WB), .FAST_W(FB)) dut_w (
    .clk (clk), .rst_n (rst_n), .clr (clr), .en (en), .count (count_b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic [WA-1:0] act, input logic [WA-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the result due after the next edge.
  task automatic drive(input logic e, input logic c);
    exp_t it;
    @(negedge clk);
    en  = e;
    clr = c;
    if (c) begin
      it.tag_a = e ? "R6" : "R5";
      it.tag_b = it.tag_a;
    end else if (!e) begin
      it.tag_a = "R4";
      it.tag_b = "R4";
    end else begin
      it.tag_a = (ref_a[FA-1:0] == '1) ? "R3" : "R2";
      it.tag_b = (ref_b == '1) ? "R7" : "R8";
    end
    ref_a = c ? '0 : (e ? ref_a + 1'b1 : ref_a);
    ref_b = c ? '0 : (e ? ref_b + 1'b1 : ref_b);
    it.exp_a    = ref_a;
    it.exp_b    = ref_b;
    it.clr_item = c;
    sb_q.push_back(it);
  endtask

  task automatic run(input logic e, input logic c, input int n);
    for (int i = 0; i < n; i++) drive(e, c);
  endtask

  // Monitor: one comparison per rising edge, sampled just after it.
  always @(posedge clk) begin
    exp_t it;
    #1;
    if (mon_on && sb_q.size() > 0) begin
      it = sb_q.pop_front();
      check(count_a == it.exp_a, it.tag_a, count_a, it.exp_a);
      check(count_b == it.exp_b, it.tag_b, WA'(count_b), WA'(it.exp_b));
      if (it.clr_item) begin
        upper_gap  = 0;
        last_upper = count_a[WA-1:FA];
      end else if (count_a[WA-1:FA] != last_upper) begin
        // R9: upper field must have rested for 2^FA - 1 earlier samples
        check(upper_gap >= (1 << FA) - 1, "R9", WA'(upper_gap), WA'((1 << FA) - 1));
        upper_gap  = 0;
        last_upper = count_a[WA-1:FA];
      end else begin
        upper_gap++;
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    mon_on = 1'b0;
    rst_n = 1'b0; clr = 1'b0; en = 1'b0;
    ref_a = '0; ref_b = '0;
    last_upper = '0; upper_gap = 0;
    repeat (3) @(negedge clk);
    // R1: zero during reset
    check(count_a == '0, "R1", count_a, '0);
    check(count_b == '0, "R1", WA'(count_b), '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: zero on the first cycle after release (en low)
    check(count_a == '0, "R1", count_a, '0);
    mon_on = 1'b1;

    run(1'b1, 1'b0, 23);          // R2/R3: 23 -> both prescalers all ones
    run(1'b0, 1'b0, 5);           // R4: hold at all ones, no carry leak
    run(1'b1, 1'b0, 1);           // R3: carry into upper field
    for (int i = 0; i < 40; i++)  // R2/R4: gapped enable
      drive((i % 3) != 0, 1'b0);
    while (ref_a[FA-1:0] != '1) drive(1'b1, 1'b0);
    run(1'b1, 1'b1, 1);           // R6: clear beats enable at all ones
    run(1'b1, 1'b0, 6);           // R6: restart from one, no stale carry
    run(1'b1, 1'b0, 5);
    run(1'b0, 1'b1, 1);           // R5: clear with enable low
    run(1'b0, 1'b0, 2);
    run(1'b1, 1'b0, 1100);        // R7/R8: narrow instance wraps
    run(1'b0, 1'b0, 2);

    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule